// File: doc/BRIEF.md
# Speculative Rename Register File

This block is a register file with two kinds of storage: a bank of architectural registers that hold committed state, and a pool of rename registers that hold results which are still speculative. The in-order retirement tracker outside the block keeps only instruction bookkeeping. Every operand, whether committed or speculative, is read from this one structure.

When an instruction is dispatched, the block gives its destination the lowest-numbered free rename register and points that architectural register's mapping entry at it. A finishing execution unit writes the rename register by broadcasting a tag and a value. At retirement, the value is copied into the architectural register and the rename register goes back to the free pool. The mapping is cleared only if it still names the retiring rename register. A flush after a misprediction frees every rename register and clears every mapping in one cycle. Read ports are combinational. Each returns the value the mapping selects and a ready flag. A read can also take the value being broadcast in that cycle.

Top module: `rename_regfile`

## Requirements
- R1: After reset all eight rename registers are free, `disp_ready` is 1, `disp_tag` is 0, and every architectural register reads 0 with ready 1.
- R2: While `disp_ready` is 1, `disp_tag` combinationally shows the lowest-numbered free rename register. When `disp_valid` is 1 and `flush` is 0 at a clock edge, that register is allocated and the mapping of `disp_arch` names it from the next cycle on.
- R3: `disp_ready` is 0 exactly when all rename registers are allocated. A dispatch attempted then changes neither the free pool nor any mapping.
- R4: Reading an architectural register whose mapping names a rename register that has not been written returns ready 0, and `rd_tag` gives that rename index.
- R5: A broadcast (`wb_valid`, `wb_tag`, `wb_data`) writes the rename register at the clock edge. From the next cycle, reads mapped to it return the value with ready 1.
- R6: A read whose mapping names the rename register being broadcast in the same cycle returns `wb_data` with ready 1 in that cycle.
- R7: A retirement (`cm_valid`, `cm_arch`, `cm_tag`) copies the rename register's value into the architectural register and frees the rename register at the clock edge. If the mapping still names `cm_tag`, it is cleared, and later reads return the architectural copy.
- R8: A retirement whose architectural register is already mapped to a newer rename register leaves that mapping in place, and reads keep returning the newer entry.
- R9: `flush` frees all rename registers and clears all mappings at the clock edge. A dispatch in the flush cycle is dropped, and a retirement in the flush cycle still updates its architectural register.
- R10: An architectural register with no live mapping reads its committed value with ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_arch | input | 3 | Destination architectural register of the dispatch |
| disp_ready | output | 1 | A rename register is free |
| disp_tag | output | 3 | Rename register the dispatch receives |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 3 | Rename register of the broadcast result |
| wb_data | input | 32 | Broadcast result value |
| cm_valid | input | 1 | Retirement valid |
| cm_arch | input | 3 | Architectural register being retired |
| cm_tag | input | 3 | Rename register being retired |
| flush | input | 1 | Discard all speculative state |
| rd_arch | input | 6 | Two 3-bit read addresses, port 0 in the low bits |
| rd_data | output | 64 | Two 32-bit read values, port 0 in the low bits |
| rd_ready | output | 2 | Per-port operand ready |
| rd_tag | output | 6 | Per-port mapped rename index |

## Verification
The read ports, `disp_ready`, `disp_tag` and the same-cycle bypass are combinational, so their checks sample them inside the cycle in which the inputs are applied. Every state change (allocation, result write, retirement, flush) appears in the cycle after its clock edge. The bench therefore drives each request just after a rising edge and checks the effect only after the following edge. Retirement and flush effects on the mapping are observed through reads and through the next `disp_tag`. This tells an architectural copy apart from a live rename entry.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int ARCH_N   = 8;
    localparam int REN_N    = 8;
    localparam int DATA_W   = 32;
    localparam int RD_PORTS = 2;
    localparam int AW       = $clog2(ARCH_N);
    localparam int TW       = $clog2(REN_N);

    typedef logic [AW-1:0]     arch_idx_t;
    typedef logic [TW-1:0]     ren_idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic     live;
        ren_idx_t tag;
    } map_ent_t;

    typedef struct packed {
        logic     en;
        ren_idx_t tag;
        word_t    data;
    } result_bus_t;

    typedef struct packed {
        logic      en;
        arch_idx_t arch;
        ren_idx_t  tag;
    } retire_t;
endpackage

// File: rtl/rrf_freelist.sv
module rrf_freelist
    import rrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic             free_en,
    input  ren_idx_t         free_tag,
    input  logic             flush,
    output logic [REN_N-1:0] free_mask,
    output logic             has_free,
    output ren_idx_t         pick_tag
);
    logic [REN_N-1:0] mask_nxt;

    always_comb begin
        pick_tag = '0;
        for (int i = REN_N - 1; i >= 0; i--) begin
            if (free_mask[i]) pick_tag = ren_idx_t'(i);
        end
    end

    assign has_free = |free_mask;

    always_comb begin
        mask_nxt = free_mask;
        if (free_en)  mask_nxt[free_tag] = 1'b1;
        if (alloc_en) mask_nxt[pick_tag] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) free_mask <= '1;
        else              free_mask <= mask_nxt;
    end
endmodule

// File: rtl/rrf_maptable.sv
module rrf_maptable
    import rrf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_en,
    input  arch_idx_t                  alloc_arch,
    input  ren_idx_t                   alloc_tag,
    input  retire_t                    retire,
    input  logic                       flush,
    output map_ent_t [ARCH_N-1:0]      map_q
);
    for (genvar a = 0; a < ARCH_N; a++) begin : g_ent
        logic hit_alloc, hit_retire;
        assign hit_alloc  = alloc_en && (alloc_arch == arch_idx_t'(a));
        assign hit_retire = retire.en && (retire.arch == arch_idx_t'(a))
                            && map_q[a].live && (map_q[a].tag == retire.tag);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                map_q[a] <= '0;
            end else if (hit_alloc) begin
                map_q[a].live <= 1'b1;
                map_q[a].tag  <= alloc_tag;
            end else if (hit_retire) begin
                map_q[a].live <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage
    import rrf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_en,
    input  ren_idx_t                alloc_tag,
    input  result_bus_t             wb,
    input  retire_t                 retire,
    input  logic                    flush,
    output word_t [ARCH_N-1:0]      arch_q,
    output word_t [REN_N-1:0]       ren_q,
    output logic  [REN_N-1:0]       rdy_q
);
    word_t retire_val;

    assign retire_val = (wb.en && wb.tag == retire.tag) ? wb.data : ren_q[retire.tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            arch_q <= '0;
        end else if (retire.en) begin
            arch_q[retire.arch] <= retire_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ren_q <= '0;
        end else if (wb.en) begin
            ren_q[wb.tag] <= wb.data;
        end
    end

    for (genvar r = 0; r < REN_N; r++) begin : g_rdy
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                rdy_q[r] <= 1'b0;
            end else if (alloc_en && alloc_tag == ren_idx_t'(r)) begin
                rdy_q[r] <= 1'b0;
            end else if (wb.en && wb.tag == ren_idx_t'(r)) begin
                rdy_q[r] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile
    import rrf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       disp_valid,
    input  logic [AW-1:0]              disp_arch,
    output logic                       disp_ready,
    output logic [TW-1:0]              disp_tag,
    input  logic                       wb_valid,
    input  logic [TW-1:0]              wb_tag,
    input  logic [DATA_W-1:0]          wb_data,
    input  logic                       cm_valid,
    input  logic [AW-1:0]              cm_arch,
    input  logic [TW-1:0]              cm_tag,
    input  logic                       flush,
    input  logic [RD_PORTS*AW-1:0]     rd_arch,
    output logic [RD_PORTS*DATA_W-1:0] rd_data,
    output logic [RD_PORTS-1:0]        rd_ready,
    output logic [RD_PORTS*TW-1:0]     rd_tag
);
    logic                  fire;
    logic [REN_N-1:0]      free_mask;
    logic                  has_free;
    ren_idx_t              pick_tag;
    map_ent_t [ARCH_N-1:0] map_q;
    word_t [ARCH_N-1:0]    arch_q;
    word_t [REN_N-1:0]     ren_q;
    logic [REN_N-1:0]      rdy_q;
    result_bus_t           wb;
    retire_t               retire;

    assign fire       = disp_valid && has_free && !flush;
    assign disp_ready = has_free;
    assign disp_tag   = pick_tag;

    assign wb.en       = wb_valid && !flush;
    assign wb.tag      = wb_tag;
    assign wb.data     = wb_data;
    assign retire.en   = cm_valid;
    assign retire.arch = cm_arch;
    assign retire.tag  = cm_tag;

    rrf_freelist u_free (
        .clk      (clk),
        .rst      (rst),
        .alloc_en (fire),
        .free_en  (cm_valid),
        .free_tag (cm_tag),
        .flush    (flush),
        .free_mask(free_mask),
        .has_free (has_free),
        .pick_tag (pick_tag)
    );

    rrf_maptable u_map (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (fire),
        .alloc_arch(disp_arch),
        .alloc_tag (pick_tag),
        .retire    (retire),
        .flush     (flush),
        .map_q     (map_q)
    );

    rrf_storage u_store (
        .clk      (clk),
        .rst      (rst),
        .alloc_en (fire),
        .alloc_tag(pick_tag),
        .wb       (wb),
        .retire   (retire),
        .flush    (flush),
        .arch_q   (arch_q),
        .ren_q    (ren_q),
        .rdy_q    (rdy_q)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        arch_idx_t a;
        map_ent_t  m;
        word_t     val;
        logic      rdy;

        assign a = rd_arch[p*AW +: AW];
        assign m = map_q[a];

        always_comb begin
            if (!m.live) begin
                val = arch_q[a];
                rdy = 1'b1;
            end else if (rdy_q[m.tag]) begin
                val = ren_q[m.tag];
                rdy = 1'b1;
            end else if (wb.en && wb.tag == m.tag) begin
                val = wb.data;
                rdy = 1'b1;
            end else begin
                val = ren_q[m.tag];
                rdy = 1'b0;
            end
        end

        assign rd_data[p*DATA_W +: DATA_W] = val;
        assign rd_ready[p]                 = rdy;
        assign rd_tag[p*TW +: TW]          = m.tag;
    end
endmodule

// File: rtl/rename_regfile_chk.sv
module rename_regfile_chk
    import rrf_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  disp_valid,
    input logic [AW-1:0]         disp_arch,
    input logic                  disp_ready,
    input logic [TW-1:0]         disp_tag,
    input logic                  wb_valid,
    input logic [TW-1:0]         wb_tag,
    input logic                  cm_valid,
    input logic [TW-1:0]         cm_tag,
    input logic                  flush,
    input logic [REN_N-1:0]      free_mask,
    input logic [REN_N-1:0]      rdy_q,
    input map_ent_t [ARCH_N-1:0] map_q
);
    logic [ARCH_N-1:0] live_v;

    always_comb begin
        for (int i = 0; i < ARCH_N; i++) live_v[i] = map_q[i].live;
    end

    // R2
    alloc_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !flush) |=> !free_mask[$past(disp_tag)]);

    // R2
    map_points_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !flush) |=>
            (map_q[$past(disp_arch)].live && map_q[$past(disp_arch)].tag == $past(disp_tag)));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!disp_ready && !cm_valid && !flush) |=> (free_mask == $past(free_mask)));

    // R5
    wb_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !flush) |=> rdy_q[$past(wb_tag)]);

    // R7
    retire_free_chk: assert property (@(posedge clk) disable iff (rst)
        cm_valid |=> free_mask[$past(cm_tag)]);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ((live_v == '0) && (&free_mask) && (rdy_q == '0)));
endmodule

bind rename_regfile rename_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .disp_valid(disp_valid),
    .disp_arch (disp_arch),
    .disp_ready(disp_ready),
    .disp_tag  (disp_tag),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .cm_valid  (cm_valid),
    .cm_tag    (cm_tag),
    .flush     (flush),
    .free_mask (free_mask),
    .rdy_q     (rdy_q),
    .map_q     (map_q)
);

// File: tb/rename_regfile_test.sv
module rename_regfile_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        disp_valid;
    logic [2:0]  disp_arch;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [31:0] wb_data;
    logic        cm_valid;
    logic [2:0]  cm_arch;
    logic [2:0]  cm_tag;
    logic        flush;
    logic [5:0]  rd_arch;
    logic [63:0] rd_data;
    logic [1:0]  rd_ready;
    logic [5:0]  rd_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rename_regfile uut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_arch(disp_arch),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_tag(cm_tag),
        .flush(flush),
        .rd_arch(rd_arch), .rd_data(rd_data), .rd_ready(rd_ready), .rd_tag(rd_tag)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 0; disp_arch = 0; wb_valid = 0; wb_tag = 0; wb_data = 0;
        cm_valid = 0; cm_arch = 0; cm_tag = 0; flush = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rd(string req, int port, logic [2:0] arch,
                      logic exp_rdy, logic [31:0] exp_data);
        rd_arch[port*3 +: 3] = arch;
        #1;
        chk(req, {31'd0, rd_ready[port]}, {31'd0, exp_rdy});
        if (exp_rdy) chk(req, rd_data[port*32 +: 32], exp_data);
    endtask

    task automatic rd_pending(string req, int port, logic [2:0] arch, logic [2:0] exp_tag);
        rd_arch[port*3 +: 3] = arch;
        #1;
        chk(req, {31'd0, rd_ready[port]}, 32'd0);
        chk(req, {29'd0, rd_tag[port*3 +: 3]}, {29'd0, exp_tag});
    endtask

    task automatic dispatch(string req, logic [2:0] arch, logic [2:0] exp_tag);
        disp_valid = 1; disp_arch = arch;
        #1;
        chk(req, {31'd0, disp_ready}, 32'd1);
        chk(req, {29'd0, disp_tag}, {29'd0, exp_tag});
        tick();
    endtask

    task automatic test_reset();
        chk("R1", {31'd0, disp_ready}, 32'd1);
        chk("R1", {29'd0, disp_tag}, 32'd0);
        rd("R1", 0, 3'd3, 1'b1, 32'd0);
        rd("R10", 1, 3'd6, 1'b1, 32'd0);
    endtask

    task automatic test_alloc();
        dispatch("R2", 3'd2, 3'd0);
        rd_pending("R4", 0, 3'd2, 3'd0);
        chk("R2", {29'd0, disp_tag}, 32'd1);
        dispatch("R2", 3'd5, 3'd1);
        rd_pending("R4", 1, 3'd5, 3'd1);
    endtask

    task automatic test_bypass();
        wb_valid = 1; wb_tag = 3'd0; wb_data = 32'hA5A5_0001;
        rd("R6", 0, 3'd2, 1'b1, 32'hA5A5_0001);
        tick();
        rd("R5", 1, 3'd2, 1'b1, 32'hA5A5_0001);
    endtask

    task automatic test_commit();
        cm_valid = 1; cm_arch = 3'd2; cm_tag = 3'd0;
        rd("R7", 0, 3'd2, 1'b1, 32'hA5A5_0001);
        tick();
        chk("R7", {29'd0, disp_tag}, 32'd0);
        dispatch("R7", 3'd7, 3'd0);
        wb_valid = 1; wb_tag = 3'd0; wb_data = 32'h0000_0077;
        tick();
        rd("R7", 0, 3'd2, 1'b1, 32'hA5A5_0001);
        rd("R5", 1, 3'd7, 1'b1, 32'h0000_0077);
    endtask

    task automatic test_stale();
        dispatch("R8", 3'd3, 3'd2);
        dispatch("R8", 3'd3, 3'd3);
        wb_valid = 1; wb_tag = 3'd2; wb_data = 32'h11;
        tick();
        wb_valid = 1; wb_tag = 3'd3; wb_data = 32'h22;
        tick();
        cm_valid = 1; cm_arch = 3'd3; cm_tag = 3'd2;
        tick();
        rd("R8", 0, 3'd3, 1'b1, 32'h22);
        chk("R8", {29'd0, rd_tag[2:0]}, 32'd3);
        chk("R7", {29'd0, disp_tag}, 32'd2);
    endtask

    task automatic test_full();
        dispatch("R2", 3'd1, 3'd2);
        dispatch("R2", 3'd1, 3'd4);
        dispatch("R2", 3'd1, 3'd5);
        dispatch("R2", 3'd1, 3'd6);
        dispatch("R2", 3'd1, 3'd7);
        chk("R3", {31'd0, disp_ready}, 32'd0);
        disp_valid = 1; disp_arch = 3'd6;
        tick();
        rd("R3", 0, 3'd6, 1'b1, 32'd0);
        chk("R3", {31'd0, disp_ready}, 32'd0);
        rd_pending("R3", 1, 3'd1, 3'd7);
    endtask

    task automatic test_flush();
        flush = 1; cm_valid = 1; cm_arch = 3'd7; cm_tag = 3'd0;
        disp_valid = 1; disp_arch = 3'd4;
        tick();
        chk("R9", {31'd0, disp_ready}, 32'd1);
        chk("R9", {29'd0, disp_tag}, 32'd0);
        rd("R9", 0, 3'd3, 1'b1, 32'h11);
        rd("R9", 1, 3'd1, 1'b1, 32'd0);
        rd("R9", 0, 3'd7, 1'b1, 32'h77);
        rd("R9", 1, 3'd4, 1'b1, 32'd0);
        rd("R9", 0, 3'd5, 1'b1, 32'd0);
        rd("R10", 1, 3'd2, 1'b1, 32'hA5A5_0001);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rd_arch = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        #1;
        test_reset();
        test_alloc();
        test_bypass();
        test_commit();
        test_stale();
        test_full();
        test_flush();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule